// File: doc/BRIEF.md
# Byte-Granular Load/Store Bridge

This block places a byte-addressed load/store port in front of a 32-bit word memory that has no per-byte write strobes. A request gives a byte address, an access width of 8, 16 or 32 bits, a direction, a signed flag for loads and store data. The memory port carries only a word index, an enable, a write flag and one word of data. Read data returns one cycle after the read is issued.

Loads fetch whole words and shift the addressed bytes down to bit 0. The result is then zero-extended or sign-extended. A store that covers a full aligned word is written directly. A narrower store reads the word first, replaces only the addressed bytes and writes the word back. An access whose bytes cross into the next word is split into one access to each of the two words. The requester sees a single request and a single completion. Only one request is in flight at a time.

Top module: `byte_lane_lsu`

## Requirements
- R1: Byte order is little-endian, so byte offset k of a word is bits [8k+7:8k]. The size codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits; code 3 behaves as 32 bits.
- R2: The memory word index is request address bits [31:2]. The second word of a split access uses that index plus one.
- R3: When the signed flag is 0, a 8-bit or 16-bit load returns the addressed bytes zero-extended to 32 bits.
- R4: When the signed flag is 1, a 8-bit or 16-bit load is sign-extended from its most significant loaded bit.
- R5: A 32-bit access at a multiple-of-4 address makes exactly one memory access. A load makes one read, and a store makes one write with no read.
- R6: A store narrower than 32 bits that stays within one word makes exactly one read and then one write to that word. Bytes of the word that were not addressed keep their old values.
- R7: Two access types cross a word boundary: a 32-bit access at offset 1, 2 or 3, and a 16-bit access at offset 3. A load of this kind makes two reads. A store of this kind makes two reads and two writes. In both cases the result is the same as for byte-by-byte access.
- R8: The port is ready only when the block is idle, and a request is taken when valid and ready are both high. Each request produces a done pulse exactly one cycle long, and rsp_rdata holds the load result during that cycle. Ready rises again only after a done pulse. No memory access is made in the done cycle.
- R9: During reset, ready is high while done and the memory enable are low.
- R10: A memory write is never issued in the cycle right after a memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The block is idle and will take a request |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access width code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load result, valid with rsp_done |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 30 | Memory word index |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, one cycle after a read |

## Verification
First, aligned full-word stores fill the memory with bytes that mix set and clear top bits. Loads are then run at every offset of several words, with every size and both extension modes. These loads separate lane selection from shifting, zero extension from sign extension, and single-word loads from two-word loads. Narrow stores at each offset, a 16-bit store at offset 3 and 32-bit stores at offsets 1 and 2 follow. A final read of every word shows whether any byte outside an addressed range was disturbed. For each request, the number of memory reads and writes is counted and checked against the split and read-modify-write rules.

// File: rtl/blsu_pkg.sv
package blsu_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int PAIR_W = 2 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD0  = 3'd1,
        ST_RD1  = 3'd2,
        ST_WAIT = 3'd3,
        ST_WR0  = 3'd4,
        ST_WR1  = 3'd5,
        ST_FIN  = 3'd6
    } seq_e;
endpackage

// File: rtl/blsu_lane_plan.sv
module blsu_lane_plan
    import blsu_pkg::*;
(
    input  logic [1:0]        off_i,
    input  logic [1:0]        size_i,
    output logic [PAIR_W-1:0] mask_o,
    output logic              split_o
);
    logic [PAIR_W-1:0] base;

    always_comb begin
        unique case (size_i)
            2'd0:    base = PAIR_W'(4'h1);
            2'd1:    base = PAIR_W'(4'h3);
            default: base = PAIR_W'(4'hF);
        endcase
        mask_o  = base << off_i;
        split_o = |mask_o[PAIR_W-1:LANES];
    end
endmodule

// File: rtl/blsu_load_align.sv
module blsu_load_align
    import blsu_pkg::*;
(
    input  logic [WORD_W-1:0] w0_i,
    input  logic [WORD_W-1:0] w1_i,
    input  logic [1:0]        off_i,
    input  logic [1:0]        size_i,
    input  logic              sgn_i,
    output logic [WORD_W-1:0] data_o
);
    logic [WORD_W-1:0] low;

    always_comb begin
        low = WORD_W'({w1_i, w0_i} >> {off_i, 3'b000});
        unique case (size_i)
            2'd0:    data_o = {{(WORD_W-BYTE_W){sgn_i & low[BYTE_W-1]}}, low[BYTE_W-1:0]};
            2'd1:    data_o = {{(WORD_W-2*BYTE_W){sgn_i & low[2*BYTE_W-1]}}, low[2*BYTE_W-1:0]};
            default: data_o = low;
        endcase
    end
endmodule

// File: rtl/blsu_store_merge.sv
module blsu_store_merge
    import blsu_pkg::*;
(
    input  logic [WORD_W-1:0] old0_i,
    input  logic [WORD_W-1:0] old1_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [1:0]        off_i,
    input  logic [PAIR_W-1:0] mask_i,
    output logic [WORD_W-1:0] new0_o,
    output logic [WORD_W-1:0] new1_o
);
    logic [2*WORD_W-1:0] shifted;
    logic [2*WORD_W-1:0] old_pair;
    logic [2*WORD_W-1:0] merged;

    assign shifted  = {{WORD_W{1'b0}}, wdata_i} << {off_i, 3'b000};
    assign old_pair = {old1_i, old0_i};

    for (genvar k = 0; k < PAIR_W; k++) begin : g_lane
        assign merged[k*BYTE_W +: BYTE_W] = mask_i[k] ? shifted[k*BYTE_W +: BYTE_W]
                                                      : old_pair[k*BYTE_W +: BYTE_W];
    end

    assign new0_o = merged[WORD_W-1:0];
    assign new1_o = merged[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/byte_lane_lsu.sv
module byte_lane_lsu
    import blsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_signed,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int WA_W = ADDR_W - 2;

    typedef struct packed {
        seq_e              st;
        logic [WA_W-1:0]   wa;
        logic [1:0]        off;
        logic [1:0]        sz;
        logic              wr;
        logic              sgn;
        logic [WORD_W-1:0] wd;
        logic              pend;
        logic              pslot;
        logic [WORD_W-1:0] b0;
        logic [WORD_W-1:0] b1;
    } ctx_t;

    localparam ctx_t CTX_RST = '{st: ST_IDLE, default: '0};

    ctx_t ctx_d, ctx_q;

    logic [PAIR_W-1:0] lane_mask;
    logic              lane_split;
    logic [WORD_W-1:0] merged0, merged1;
    logic              req_full;

    blsu_lane_plan u_plan (
        .off_i   (ctx_q.off),
        .size_i  (ctx_q.sz),
        .mask_o  (lane_mask),
        .split_o (lane_split)
    );

    blsu_load_align u_align (
        .w0_i   (ctx_q.b0),
        .w1_i   (ctx_q.b1),
        .off_i  (ctx_q.off),
        .size_i (ctx_q.sz),
        .sgn_i  (ctx_q.sgn),
        .data_o (rsp_rdata)
    );

    blsu_store_merge u_merge (
        .old0_i  (ctx_q.b0),
        .old1_i  (ctx_q.b1),
        .wdata_i (ctx_q.wd),
        .off_i   (ctx_q.off),
        .mask_i  (lane_mask),
        .new0_o  (merged0),
        .new1_o  (merged1)
    );

    assign req_full  = req_size[1] && (req_addr[1:0] == 2'b00);
    assign req_ready = (ctx_q.st == ST_IDLE);

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.pend  = 1'b0;
        ctx_d.pslot = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctx_q.wa;
        mem_wdata = merged0;
        rsp_done  = 1'b0;

        if (ctx_q.pend) begin
            if (ctx_q.pslot) ctx_d.b1 = mem_rdata;
            else             ctx_d.b0 = mem_rdata;
        end

        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.wa  = req_addr[ADDR_W-1:2];
                    ctx_d.off = req_addr[1:0];
                    ctx_d.sz  = req_size;
                    ctx_d.wr  = req_write;
                    ctx_d.sgn = req_signed;
                    ctx_d.wd  = req_wdata;
                    ctx_d.st  = (req_write && req_full) ? ST_WR0 : ST_RD0;
                end
            end
            ST_RD0: begin
                mem_en      = 1'b1;
                ctx_d.pend  = 1'b1;
                ctx_d.st    = lane_split ? ST_RD1 : ST_WAIT;
            end
            ST_RD1: begin
                mem_en      = 1'b1;
                mem_addr    = ctx_q.wa + WA_W'(1);
                ctx_d.pend  = 1'b1;
                ctx_d.pslot = 1'b1;
                ctx_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                ctx_d.st = ctx_q.wr ? ST_WR0 : ST_FIN;
            end
            ST_WR0: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = merged0;
                ctx_d.st  = lane_split ? ST_WR1 : ST_FIN;
            end
            ST_WR1: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.wa + WA_W'(1);
                mem_wdata = merged1;
                ctx_d.st  = ST_FIN;
            end
            ST_FIN: begin
                rsp_done = 1'b1;
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= CTX_RST;
        else        ctx_q <= ctx_d;
    end
endmodule

// File: rtl/blsu_chk.sv
module blsu_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic mem_en,
    input logic mem_we
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(rsp_done));

    // R8
    quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !mem_en);

    // R10
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> !(mem_en && mem_we));
endmodule

bind byte_lane_lsu blsu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
);

// File: tb/sim_byte_lane_lsu.sv
module sim_byte_lane_lsu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic        req_signed;
    logic [31:0] req_wdata;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        mem_en;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    always #5 clk = ~clk;

    byte_lane_lsu u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_write  (req_write),
        .req_signed (req_signed),
        .req_wdata  (req_wdata),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    logic [31:0] mem_model [16];
    logic [7:0]  ref_mem   [64];
    int n_rd, n_wr;
    int checks = 0;
    int fails  = 0;

    initial begin
        for (int i = 0; i < 16; i++) mem_model[i] = '0;
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_model[mem_addr[3:0]] <= mem_wdata;
            else        mem_rdata <= mem_model[mem_addr[3:0]];
        end
    end

    always @(posedge clk) begin
        if (req_valid && req_ready) begin
            n_rd <= 0;
            n_wr <= 0;
        end else if (mem_en) begin
            if (mem_we) n_wr <= n_wr + 1;
            else        n_rd <= n_rd + 1;
        end
    end

    typedef struct {
        logic        ld;
        logic [31:0] data;
        int          rds;
        int          wrs;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic send(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic sg, input logic [31:0] wd, input string tag);
        int    n;
        int    off;
        int    nw;
        exp_t  e;
        logic [31:0] v;
        n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        off = int'(a[1:0]);
        nw  = (off + n > 4) ? 2 : 1;
        e.ld  = !wr;
        e.tag = tag;
        if (wr) begin
            for (int i = 0; i < n; i++) ref_mem[(int'(a) + i) % 64] = wd[8*i +: 8];
            e.rds  = (n == 4 && off == 0) ? 0 : nw;
            e.wrs  = nw;
            e.data = '0;
        end else begin
            v = '0;
            for (int i = 0; i < n; i++) v[8*i +: 8] = ref_mem[(int'(a) + i) % 64];
            if (sg && n == 1) v = {{24{v[7]}}, v[7:0]};
            if (sg && n == 2) v = {{16{v[15]}}, v[15:0]};
            e.rds  = nw;
            e.wrs  = 0;
            e.data = v;
        end
        sb_q.push_back(e);
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        req_valid  = 1'b1;
        req_addr   = a;
        req_size   = sz;
        req_write  = wr;
        req_signed = sg;
        req_wdata  = wd;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    // Monitor: pops the expected item at each done pulse.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_done) begin
                if (sb_q.size() == 0) begin
                    chk("R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = sb_q.pop_front();
                    if (e.ld) chk({e.tag, " data"}, rsp_rdata, e.data);
                    chk({e.tag, " reads"},  32'(n_rd), 32'(e.rds));
                    chk({e.tag, " writes"}, 32'(n_wr), 32'(e.wrs));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        string tg;
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_addr   = '0;
        req_size   = '0;
        req_write  = 1'b0;
        req_signed = 1'b0;
        req_wdata  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 ready", 32'(req_ready), 32'd1);
        chk("R9 done",  32'(rsp_done),  32'd0);
        chk("R9 mem_en", 32'(mem_en),   32'd0);
        rst_n = 1'b1;

        // R5 aligned full-word stores fill memory
        for (int w = 0; w < 16; w++)
            send(32'(w * 4), 2'd2, 1'b1, 1'b0, 32'h F183_72E4 + 32'(w) * 32'h1B2A_3948,
                 "R5 R2 aligned store");

        // Loads of every size, offset and extension mode
        for (int a = 0; a < 12; a++)
            for (int sz = 0; sz < 3; sz++)
                for (int sg = 0; sg < 2; sg++) begin
                    tg = (sg != 0) ? "R4 load" : "R3 load";
                    if ((a % 4) != 0) tg = {tg, " R1"};
                    if ((sz == 2 && (a % 4) != 0) || (sz == 1 && (a % 4) == 3)) tg = {tg, " R7 split"};
                    else if (sz == 2) tg = {tg, " R5 aligned"};
                    send(32'(a), 2'(sz), 1'b0, 1'(sg), 32'h0, tg);
                end

        // Size code 3 behaves as 32 bits
        send(32'd8, 2'd3, 1'b0, 1'b0, 32'h0, "R1 size3 load");

        // R6 narrow stores within one word
        send(32'd16, 2'd0, 1'b1, 1'b0, 32'h0000_00A5, "R6 byte store off0");
        send(32'd17, 2'd0, 1'b1, 1'b0, 32'h0000_005A, "R6 byte store off1");
        send(32'd18, 2'd0, 1'b1, 1'b0, 32'h0000_00C3, "R6 byte store off2");
        send(32'd19, 2'd0, 1'b1, 1'b0, 32'h0000_003C, "R6 byte store off3");
        send(32'd20, 2'd1, 1'b1, 1'b0, 32'h0000_BEEF, "R6 half store off0");
        send(32'd26, 2'd1, 1'b1, 1'b0, 32'h0000_8001, "R6 half store off2");
        send(32'd29, 2'd0, 1'b1, 1'b0, 32'h0000_0077, "R6 byte store isolated");

        // R7 split stores
        send(32'd23, 2'd1, 1'b1, 1'b0, 32'h0000_1234, "R7 half split store");
        send(32'd33, 2'd2, 1'b1, 1'b0, 32'hDEAD_C0DE, "R7 word split store off1");
        send(32'd42, 2'd2, 1'b1, 1'b0, 32'h9ABC_4321, "R7 word split store off2");
        send(32'd51, 2'd2, 1'b1, 1'b0, 32'h0F1E_2D3C, "R7 word split store off3");
        send(32'd56, 2'd2, 1'b1, 1'b0, 32'h5566_7788, "R5 aligned store direct");

        // Loads across the modified region
        send(32'd23, 2'd1, 1'b0, 1'b1, 32'h0, "R7 R4 split half load");
        send(32'd27, 2'd0, 1'b0, 1'b1, 32'h0, "R4 byte load");
        send(32'd26, 2'd1, 1'b0, 1'b1, 32'h0, "R4 half load");
        send(32'd33, 2'd2, 1'b0, 1'b0, 32'h0, "R7 split word load");

        // Readback of every word: untouched bytes intact
        for (int w = 0; w < 16; w++)
            send(32'(w * 4), 2'd2, 1'b0, 1'b0, 32'h0, "R6 R7 R2 readback");

        wait (sb_q.size() == 0);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule